// File: doc/BRIEF.md
# Watchdog Timer with Per-CPU Reset or Interrupt Action

This block is a watchdog timer on a simple synchronous register bus. Software programs a terminal count, a set of CPUs to reset, an interrupt enable and a run enable in one control word. While the watchdog is enabled, an elapsed counter advances once per timebase unit of 10 microseconds. A prescaler divides the system clock to produce that unit; its division ratio is a parameter, for example 1000 at 100 MHz. A timeout of T ns is therefore programmed as ceil(T/10000). Software services the watchdog by writing zero to the count word, which restarts both the elapsed count and the prescaler.

When the elapsed count reaches the terminal count, the block acts. If the CPU mask is nonzero, it drives a reset request for every CPU whose mask bit is set. If the mask is zero and the interrupt enable is set, it raises an interrupt instead. After a timeout the counter holds at the terminal count. The action stays asserted until software restarts the count or clears the enable bit.

Control word layout, at byte offset 0:
- terminal count: bits [TC_W-1:0]
- run enable: bit EN_BIT (22 by default; the narrow build uses bit 19 with a 19-bit count)
- interrupt enable: bit 23
- CPU mask: bits [24+CPU_W-1:24]

The count word is at byte offset 4. It reads the elapsed count, zero-extended. Address bit 2 selects between the two words.

The sequencer has three states:
- IDLE: disabled. Counter and prescaler are held at zero.
- RUN: counting.
- EXPIRED: timeout action asserted, counter frozen.

Its transitions are:
- IDLE→RUN (arm): the enable bit is seen set.
- RUN→EXPIRED (timeout): the elapsed count is at or above the terminal count.
- RUN→RUN and EXPIRED→RUN (service): a zero is written to the count word.
- any→IDLE (disarm): the enable bit is seen clear.

A register write takes effect on the next clock edge. The sequencer acts on the stored control word one edge after that. Both outputs are registered levels.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0, the count word reads 0, cpu_rst_o is 0 and irq_o is 0.
- R2: A write to byte offset 0 (address bit 2 = 0) stores all 32 data bits; reading offset 0 returns them.
- R3: Reading offset 4 returns the elapsed count, zero-extended. It stays 0 while the enable bit is clear.
- R4: While enabled and counting, the elapsed count rises by one every TICK_CYCLES clock cycles.
- R5: When the elapsed count reaches the terminal count and the CPU mask is nonzero, cpu_rst_o equals the mask. The count then freezes at the terminal count.
- R6: With a zero CPU mask, a timeout raises irq_o only if the interrupt enable (bit 23) is set. With both clear, a timeout drives neither output. irq_o and cpu_rst_o are never both active.
- R7: Writing the value 0 to offset 4 clears the elapsed count and the prescaler and drops any active timeout action. Regular servicing therefore prevents a timeout.
- R8: Writing a nonzero value to offset 4 has no effect on the count or on the outputs.
- R9: Writing a control word with the enable and interrupt enable bits both clear returns the count to 0 and deasserts cpu_rst_o and irq_o.
- R10: A terminal count of 0 causes a timeout immediately after the watchdog arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address; bit 2 selects count (1) or control (0) |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word |
| cpu_rst_o | output | CPU_W | Per-CPU reset requests |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The bench tries the timeout path with three kinds of action setting:
- a nonzero CPU mask, which tells reset routing apart from the interrupt path;
- a zero mask with the interrupt enable set, which checks that the interrupt is the fallback;
- a zero mask with the interrupt enable clear, which must stay silent.

It drives three patterns on the count word. A zero written on a steady period shorter than the timeout must hold the outputs low forever. A nonzero write must change nothing. A zero written after a timeout must re-arm the watchdog. A terminal count of zero and a disarming control write exercise the two boundaries. A behavioural reference model is compared on every clock against the outputs and against every count read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W     = 32;
    localparam int IRQ_EN_BIT = 23;
    localparam int MASK_LSB   = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_EXPIRED
    } wd_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int TC_W   = 22,
    parameter int EN_BIT = 22,
    parameter int CPU_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [TC_W-1:0]   cnt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic              irq_en_o,
    output logic [CPU_W-1:0]  mask_o,
    output logic [TC_W-1:0]   tc_o,
    output logic              restart_o
);

    localparam int SEL_BIT = 2;

    logic [DATA_W-1:0] ctrl_q;
    logic              sel_cnt;

    assign sel_cnt = addr_i[SEL_BIT];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (we_i && !sel_cnt) begin
            ctrl_q <= wdata_i;
        end
    end

    assign restart_o = we_i && sel_cnt && (wdata_i == '0);

    assign en_o     = ctrl_q[EN_BIT];
    assign irq_en_o = ctrl_q[IRQ_EN_BIT];
    assign mask_o   = ctrl_q[MASK_LSB +: CPU_W];
    assign tc_o     = ctrl_q[TC_W-1:0];

    always_comb begin
        if (sel_cnt) begin
            rdata_o = {{(DATA_W-TC_W){1'b0}}, cnt_i};
        end else begin
            rdata_o = ctrl_q;
        end
    end

    AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && !sel_cnt) |=> $stable(ctrl_q)); // R8

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);

    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

    generate
        if (TICK_CYCLES == 1) begin : g_direct
            assign tick_o = run_i && !clear_i;
        end else begin : g_div
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    pre_q <= '0;
                end else if (!run_i || clear_i) begin
                    pre_q <= '0;
                end else if (pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick_o = run_i && !clear_i && (pre_q == LAST);

            AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
                pre_q <= LAST); // R4
            AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                clear_i |=> (pre_q == '0)); // R7
        end
    endgenerate

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int TC_W  = 22,
    parameter int CPU_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             irq_en_i,
    input  logic [CPU_W-1:0] mask_i,
    input  logic [TC_W-1:0]  tc_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [TC_W-1:0]  cnt_o,
    output logic             run_o,
    output logic [CPU_W-1:0] cpu_rst_o,
    output logic             irq_o
);

    wd_state_e       state_q, state_d;
    logic [TC_W-1:0] cnt_q;
    logic            at_limit;

    assign at_limit = (cnt_q >= tc_i);
    assign run_o    = en_i && (state_q == ST_RUN);
    assign cnt_o    = cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_i)          state_d = ST_IDLE;
                else if (restart_i) state_d = ST_RUN;
                else if (at_limit)  state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!en_i)          state_d = ST_IDLE;
                else if (restart_i) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!en_i || state_q == ST_IDLE || restart_i) begin
            cnt_q <= '0;
        end else if (state_q == ST_RUN && tick_i && !at_limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cpu_rst_o <= '0;
            irq_o     <= 1'b0;
        end else begin
            cpu_rst_o <= (state_d == ST_EXPIRED) ? mask_i : '0;
            irq_o     <= (state_d == ST_EXPIRED) && (mask_i == '0) && irq_en_i;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0)); // R3
    AST_RST_ONLY_EXPIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_rst_o != '0) |-> (state_q == ST_EXPIRED)); // R5
    AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_EXPIRED && en_i && !restart_i) |=> $stable(cnt_q)); // R5
    AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (cpu_rst_o == '0)); // R6
    AST_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (cnt_q == '0 && irq_o == 1'b0 && cpu_rst_o == '0)); // R7
    AST_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_q == ST_IDLE && !irq_o)); // R9

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_CYCLES = 1000,
    parameter int TC_W        = 22,
    parameter int EN_BIT      = 22,
    parameter int CPU_W       = 4,
    parameter int ADDR_W      = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [CPU_W-1:0]  cpu_rst_o,
    output logic              irq_o
);

    logic             en;
    logic             irq_en;
    logic [CPU_W-1:0] mask;
    logic [TC_W-1:0]  tc;
    logic [TC_W-1:0]  cnt;
    logic             restart;
    logic             run;
    logic             tick;

    wdog_regs #(
        .TC_W   (TC_W),
        .EN_BIT (EN_BIT),
        .CPU_W  (CPU_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .we_i      (we_i),
        .wdata_i   (wdata_i),
        .cnt_i     (cnt),
        .rdata_o   (rdata_o),
        .en_o      (en),
        .irq_en_o  (irq_en),
        .mask_o    (mask),
        .tc_o      (tc),
        .restart_o (restart)
    );

    wdog_prescale #(
        .TICK_CYCLES (TICK_CYCLES)
    ) i_prescale (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .clear_i (restart),
        .tick_o  (tick)
    );

    wdog_fsm #(
        .TC_W  (TC_W),
        .CPU_W (CPU_W)
    ) i_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en),
        .irq_en_i  (irq_en),
        .mask_i    (mask),
        .tc_i      (tc),
        .restart_i (restart),
        .tick_i    (tick),
        .cnt_o     (cnt),
        .run_o     (run),
        .cpu_rst_o (cpu_rst_o),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int EN         = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cpu_rst;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ctrl;
    int          m_st, m_cnt, m_pre;
    logic [3:0]  m_rst;
    logic        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer #(.TICK_CYCLES(N)) i_wdog_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .we_i      (we),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .cpu_rst_o (cpu_rst),
        .irq_o     (irq)
    );

    // Behavioural reference: state 0 disabled, 1 counting, 2 timed out.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_st = 0; m_cnt = 0; m_pre = 0; m_rst = 0; m_irq = 0;
        end else begin
            int tc, ns, nc, np;
            bit en, restart;
            en = m_ctrl[EN];
            tc = int'(m_ctrl[21:0]);
            restart = we && addr[2] && (wdata == 0);
            ns = m_st; nc = m_cnt; np = m_pre;
            if (!en) begin
                ns = 0; nc = 0; np = 0;
            end else if (m_st == 0) begin
                ns = 1; nc = 0; np = 0;
            end else if (restart) begin
                ns = 1; nc = 0; np = 0;
            end else if (m_st == 1) begin
                if (m_cnt >= tc) begin
                    ns = 2; np = 0;
                end else if (m_pre == N-1) begin
                    np = 0; nc = m_cnt + 1;
                end else begin
                    np = m_pre + 1;
                end
            end else begin
                np = 0;
            end
            m_rst = (ns == 2) ? m_ctrl[27:24] : 4'h0;
            m_irq = (ns == 2) && (m_ctrl[27:24] == 0) && m_ctrl[23];
            if (we && !addr[2]) m_ctrl = wdata;
            m_st = ns; m_cnt = nc; m_pre = np;
        end
    end

    // Compare outputs on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (cpu_rst !== m_rst || irq !== m_irq) begin
                errors++;
                $display("FAIL R5 R6 outputs: cpu_rst=%h irq=%b expected cpu_rst=%h irq=%b",
                         cpu_rst, irq, m_rst, m_irq);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_cnt(input string req);
        addr = 3'd4; #1;
        chk(req, rdata, 32'(m_cnt));
    endtask

    function automatic logic [31:0] ctl(input logic [3:0] mask, input bit ie,
                                        input bit en, input int tc);
        return {4'h0, mask, ie, EN == 22 ? 1'b1 : 1'b0, 22'(tc)} &
               (en ? 32'hFFFF_FFFF : ~(32'h1 << EN));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        addr = 3'd0; #1; chk("R1 ctrl", rdata, 32'h0);
        addr = 3'd4; #1; chk("R1 count", rdata, 32'h0);
        chk("R1 outputs", {27'h0, cpu_rst, irq}, 32'h0);

        // R2 / R3: stored but disabled
        wr(3'd0, ctl(4'h3, 0, 0, 5));
        addr = 3'd0; #1; chk("R2 readback", rdata, ctl(4'h3, 0, 0, 5));
        cyc(20);
        rd_cnt("R3 disabled count");
        chk("R3 disabled count literal", rdata, 32'h0);

        // R4 / R5: reset action with mask 0101, tc=3
        wr(3'd0, ctl(4'h5, 0, 1, 3));
        cyc(6);  rd_cnt("R4 count mid");
        cyc(4);  rd_cnt("R4 count later");
        cyc(20); rd_cnt("R5 frozen count");
        chk("R5 cpu_rst", {28'h0, cpu_rst}, 32'h5);

        // R8: nonzero count write ignored
        wr(3'd4, 32'h55);
        cyc(2); rd_cnt("R8 count kept");
        chk("R8 cpu_rst kept", {28'h0, cpu_rst}, 32'h5);

        // R7: zero restarts, then periodic servicing prevents a timeout
        wr(3'd4, 32'h0);
        chk("R7 cpu_rst dropped", {28'h0, cpu_rst}, 32'h0);
        rd_cnt("R7 count cleared");
        for (int i = 0; i < 6; i++) begin
            cyc(6);
            wr(3'd4, 32'h0);
        end
        chk("R7 serviced no reset", {28'h0, cpu_rst}, 32'h0);

        // R6: interrupt fallback
        wr(3'd0, ctl(4'h0, 1, 1, 2));
        cyc(30);
        chk("R6 irq raised", {31'h0, irq}, 32'h1);
        chk("R6 no reset with irq", {28'h0, cpu_rst}, 32'h0);

        // R9: clear both bits
        wr(3'd0, 32'h0);
        cyc(2);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        rd_cnt("R9 count zero");

        // R6: silent timeout
        wr(3'd0, ctl(4'h0, 0, 1, 2));
        cyc(30);
        chk("R6 silent", {27'h0, cpu_rst, irq}, 32'h0);
        rd_cnt("R6 silent count");
        wr(3'd0, 32'h0);
        cyc(3);

        // R10: terminal count zero
        wr(3'd0, ctl(4'hF, 0, 1, 0));
        cyc(3);
        chk("R10 immediate", {28'h0, cpu_rst}, 32'hF);
        wr(3'd0, 32'h0);
        cyc(3);
        chk("R9 reset cleared", {28'h0, cpu_rst}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule